// File: doc/BRIEF.md
# Serial Register-Access Slave with Selectable Bit Order

This block lets an external serial master read and write a bank of 32 byte-wide registers. A transaction is framed by an active-low select. The master clocks serial data in on `sdio_in`. Read data leaves on `sdo_out` in 4-wire operation, or on `sdio_out` in 3-wire operation. Each transaction opens with an instruction byte. That byte holds a direction flag, a byte count and a 5-bit start address. One to four data bytes follow it. After every data byte the working address moves by one.

Register 0 configures the port itself. Bit 7 selects 3-wire operation, in which read data returns on the shared line. Bit 6 selects least-significant-bit-first order. Writing 1 to bit 5 triggers a soft reset. A write to register 0 takes effect as soon as its last bit arrives, so any bytes that remain in the same transaction already follow the new settings. The select, clock and data inputs are sampled with the system clock `clk`. They are assumed to be synchronous to it already, and each serial clock phase lasts at least two `clk` cycles. All 32 registers drive the converter core through `regs_flat`.

Top module: `cfg_spi_slave`

## Requirements
- R1: After `rst_n` is low at a `clk` edge, all 32 registers read 0x00, so `regs_flat` is all zeros. This means 4-wire operation with MSB-first order.
- R2: While `csb` is high, `sdo_oe` and `sdio_oe` are both 0.
- R3: Input bits are taken on rising `sclk` edges. In MSB-first order (register 0 bit 6 = 0), the instruction bits arrive as direction (1 = read), count[1], count[0], then address[4] down to address[0]. Data bytes also arrive most significant bit first.
- R4: With register 0 bit 6 = 1, every byte is sent least significant bit first. The instruction therefore arrives as address[0] up to address[4], then count[0], count[1], and finally the direction flag.
- R5: A transaction carries count+1 data bytes (1 to 4). Any further `sclk` edges before `csb` rises are ignored.
- R6: In MSB-first order the address decrements after each data byte and holds at 0x00. In LSB-first order it increments and holds at 0x1F. Neither direction wraps.
- R7: During a read, each data bit is driven on a falling `sclk` edge, beginning with the edge after the last instruction bit. The bit appears on `sdo_out` with `sdo_oe` = 1 when register 0 bit 7 = 0. It appears on `sdio_out` with `sdio_oe` = 1 and `sdo_oe` = 0 when bit 7 = 1.
- R8: A write to register 0 changes the bit order, the step direction and the wire mode for the remaining bytes of the same transaction.
- R9: Writing register 0 with bit 5 = 1 clears every register except registers 0 and 4. Register 0 keeps the other written bits, and bit 5 always reads back as 0.
- R10: If `csb` rises partway through a byte, the partial byte is discarded. The next transaction starts with a fresh instruction byte.
- R11: Whatever the current configuration, the following sequence leaves register 0 at 0x00: within one transaction, 1 to 7 zero bits followed by three 0x00 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| csb | input | 1 | Active-low transaction select |
| sclk | input | 1 | Serial clock from the master, idle low |
| sdio_in | input | 1 | Serial data into the block |
| sdio_out | output | 1 | Read data on the shared line in 3-wire operation |
| sdio_oe | output | 1 | Drive enable for the shared line |
| sdo_out | output | 1 | Read data on the separate output in 4-wire operation |
| sdo_oe | output | 1 | Drive enable for the separate output |
| regs_flat | output | 256 | Register bank; register i occupies bits 8i+7 to 8i |

## Verification
A serial clock edge is seen one `clk` cycle after the pin changes. A read bit is therefore valid on its output one cycle after the falling `sclk` edge. A written byte reaches `regs_flat` one cycle after the eighth rising edge, and a soft reset lands in that same cycle. The bench holds each serial clock phase for three `clk` cycles and samples outputs at the end of the low phase. It checks `regs_flat` and the enables only after `csb` has been high for three cycles, well clear of every update. Expected bytes come from a bench model of the register file that tracks the configuration byte by byte, including changes made in the middle of a transaction.

// File: rtl/cfg_spi_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the serial register-access slave.
// Assumes an 8-bit instruction: direction, 2-bit count, 5-bit address.
package cfg_spi_pkg;
    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int NREG     = 1 << ADDR_W;
    localparam int CNT_W    = 2;
    localparam int BIDIR_B  = 7;   // register 0: 3-wire select
    localparam int LSBF_B   = 6;   // register 0: LSB-first select
    localparam int SRST_B   = 5;   // register 0: soft reset trigger
    localparam int KEEP_REG = 4;   // survives soft reset besides reg 0

    typedef enum logic [1:0] {PH_INSTR, PH_DATA, PH_DONE} phase_t;
endpackage

// File: rtl/cfg_spi_edge.sv
`timescale 1ns/1ps
// Detects rising and falling edges of the serial clock in the clk domain.
// Assumes sclk is already synchronous to clk and idles low at reset.
module cfg_spi_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    output logic rise,
    output logic fall
);
    logic sclk_q;

    // Remember the previous serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk;
    end

    assign rise = sclk & ~sclk_q;
    assign fall = ~sclk & sclk_q;
endmodule

// File: rtl/cfg_spi_bank.sv
`timescale 1ns/1ps
// Register bank with one write port, one combinational read port and the
// soft reset that register 0 triggers. Assumes NREG > KEEP_REG.
module cfg_spi_bank
    import cfg_spi_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int NR = NREG,
    parameter int KR = KEEP_REG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata,
    output logic [NR*DW-1:0] regs_flat
);
    logic [DW-1:0] regs [NR];

    // Store writes; a soft reset clears all but register 0 and KR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NR; i++) regs[i] <= '0;
        end else if (we) begin
            if (waddr == '0) begin
                regs[0] <= wdata & ~(DW'(1) << SRST_B);
                if (wdata[SRST_B]) begin
                    for (int i = 1; i < NR; i++)
                        if (i != KR) regs[i] <= '0;
                end
            end else begin
                regs[waddr] <= wdata;
            end
        end
    end

    assign rdata = regs[raddr];

    genvar g;
    generate
        for (g = 0; g < NR; g++) begin : g_flat
            assign regs_flat[g*DW +: DW] = regs[g];
        end
    endgenerate

    // R9
    srst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0 && wdata[SRST_B]) |=> (regs[1] == '0 && regs[0][SRST_B] == 1'b0));
    // R9
    srst_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == '0 && wdata[SRST_B]) |=> (regs[KR] == $past(regs[KR])));
endmodule

// File: rtl/cfg_spi_ctrl.sv
`timescale 1ns/1ps
// Serial engine: assembles bytes in the selected order, decodes the
// instruction, steps the address with saturation and shifts out read bits.
// Assumes a serial clock phase lasts at least two clk cycles.
module cfg_spi_ctrl
    import cfg_spi_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = BYTE_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          csb,
    input  logic          sdio_in,
    input  logic          sclk_rise,
    input  logic          sclk_fall,
    input  logic          cfg_lsb,
    input  logic [DW-1:0] rdata,
    output logic          we,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          out_bit,
    output logic          rd_active
);
    localparam int BCW = $clog2(DW);
    localparam logic [AW-1:0] ADDR_MAX = '1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

    phase_t         phase;
    logic [BCW-1:0] bit_cnt;
    logic [DW-1:0]  shreg, nxt_sh;
    logic           rw;
    logic [CW-1:0]  left;
    logic           byte_done, new_lsb;
    logic [AW-1:0]  addr_step;

    // Shift the incoming bit in from the end the current order selects.
    always_comb begin
        nxt_sh = cfg_lsb ? {sdio_in, shreg[DW-1:1]} : {shreg[DW-2:0], sdio_in};
    end

    assign byte_done = !csb && sclk_rise && (bit_cnt == LAST_BIT) && (phase != PH_DONE);
    assign we        = byte_done && (phase == PH_DATA) && !rw;
    assign wdata     = nxt_sh;

    // Choose step direction from the order in force once this byte lands.
    always_comb begin
        new_lsb = (we && addr == '0) ? nxt_sh[LSBF_B] : cfg_lsb;
        if (new_lsb) addr_step = (addr == ADDR_MAX) ? addr : addr + AW'(1);
        else         addr_step = (addr == '0)       ? addr : addr - AW'(1);
    end

    // Track bit position, phase, byte count and address of the transaction.
    always_ff @(posedge clk) begin
        if (!rst_n || csb) begin
            phase   <= PH_INSTR;
            bit_cnt <= '0;
            shreg   <= '0;
            if (!rst_n) begin
                rw   <= 1'b0;
                left <= '0;
                addr <= '0;
            end
        end else if (sclk_rise && phase != PH_DONE) begin
            bit_cnt <= bit_cnt + BCW'(1);
            shreg   <= nxt_sh;
            if (bit_cnt == LAST_BIT) begin
                if (phase == PH_INSTR) begin
                    rw    <= nxt_sh[DW-1];
                    left  <= nxt_sh[DW-2 -: CW];
                    addr  <= nxt_sh[AW-1:0];
                    phase <= PH_DATA;
                end else begin
                    addr <= addr_step;
                    if (left == '0) phase <= PH_DONE;
                    else            left  <= left - CW'(1);
                end
            end
        end
    end

    // Present the next read bit on each falling serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_bit <= 1'b0;
        else if (sclk_fall && phase == PH_DATA && rw)
            out_bit <= cfg_lsb ? rdata[bit_cnt] : rdata[LAST_BIT - bit_cnt];
    end

    assign rd_active = !csb && (phase == PH_DATA) && rw;

    // R10
    csb_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb |=> (phase == PH_INSTR && bit_cnt == '0));
    // R6
    addr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && addr == '0 && !new_lsb) |=> (addr == '0));
    // R6
    addr_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && addr == ADDR_MAX && new_lsb) |=> (addr == ADDR_MAX));
    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && phase == PH_DATA && left != '0) |=> (left == $past(left) - CW'(1)));
endmodule

// File: rtl/cfg_spi_slave.sv
`timescale 1ns/1ps
// Top of the serial register-access slave: edge detection, serial engine,
// register bank and output-enable selection for 3-wire or 4-wire use.
// Assumes csb, sclk and sdio_in are synchronous to clk.
module cfg_spi_slave
    import cfg_spi_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csb,
    input  logic                   sclk,
    input  logic                   sdio_in,
    output logic                   sdio_out,
    output logic                   sdio_oe,
    output logic                   sdo_out,
    output logic                   sdo_oe,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    logic              rise, fall, we, out_bit, rd_active;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wdata, rdata;
    logic              cfg_bidir, cfg_lsb;

    assign cfg_bidir = regs_flat[BIDIR_B];
    assign cfg_lsb   = regs_flat[LSBF_B];

    cfg_spi_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .rise(rise), .fall(fall)
    );

    cfg_spi_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .csb(csb), .sdio_in(sdio_in),
        .sclk_rise(rise), .sclk_fall(fall), .cfg_lsb(cfg_lsb),
        .rdata(rdata), .we(we), .addr(addr), .wdata(wdata),
        .out_bit(out_bit), .rd_active(rd_active)
    );

    cfg_spi_bank u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(addr), .wdata(wdata),
        .raddr(addr), .rdata(rdata), .regs_flat(regs_flat)
    );

    assign sdo_oe   = rd_active & ~cfg_bidir;
    assign sdio_oe  = rd_active &  cfg_bidir;
    assign sdo_out  = out_bit;
    assign sdio_out = out_bit;

    // R2
    idle_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        csb |-> (!sdo_oe && !sdio_oe));
    // R7
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sdo_oe, sdio_oe}));
endmodule

// File: tb/cfg_spi_slave_bench.sv
`timescale 1ns/1ps
module cfg_spi_slave_bench;
    logic clk = 1'b0, rst_n = 1'b0, csb = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
    logic sdio_out, sdio_oe, sdo_out, sdo_oe;
    logic [255:0] regs_flat;
    logic [7:0] m [32];
    int total = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cfg_spi_slave u_cfg_spi_slave (
        .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdio_in(sdio_in),
        .sdio_out(sdio_out), .sdio_oe(sdio_oe), .sdo_out(sdo_out),
        .sdo_oe(sdo_oe), .regs_flat(regs_flat)
    );

    function automatic logic [4:0] step(input logic [4:0] a, input logic lsb);
        if (lsb) return (a == 5'd31) ? a : a + 5'd1;
        return (a == 5'd0) ? a : a - 5'd1;
    endfunction

    function automatic void model_write(input logic [4:0] a, input logic [7:0] v);
        if (a == 5'd0) begin
            m[0] = v & 8'hDF;
            if (v[5]) for (int i = 1; i < 32; i++) if (i != 4) m[i] = 8'h00;
        end else m[a] = v;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag);
        int bad = -1;
        for (int i = 0; i < 32; i++) if (regs_flat[i*8 +: 8] !== m[i] && bad < 0) bad = i;
        total++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg%0d actual=%0h expected=%0h", tag, bad, regs_flat[bad*8 +: 8], m[bad]);
        end
    endtask

    task automatic clk_bit(input logic din, output logic dout, output logic so, output logic sio);
        @(negedge clk); sclk = 1'b0; sdio_in = din;
        repeat (3) @(negedge clk);
        dout = m[0][7] ? sdio_out : sdo_out;
        so = sdo_oe; sio = sdio_oe;
        sclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        logic lsb = m[0][6];
        logic d, s1, s2;
        for (int k = 0; k < 8; k++) clk_bit(lsb ? b[k] : b[7-k], d, s1, s2);
    endtask

    task automatic recv_byte(output logic [7:0] b, output logic oe_ok);
        logic lsb = m[0][6];
        logic d, s1, s2;
        oe_ok = 1'b1; b = 8'h00;
        for (int k = 0; k < 8; k++) begin
            clk_bit(1'b0, d, s1, s2);
            b = lsb ? {d, b[7:1]} : {b[6:0], d};
            if (s1 !== !m[0][7] || s2 !== m[0][7]) oe_ok = 1'b0;
        end
    endtask

    task automatic start_cycle();
        @(negedge clk); csb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic end_cycle();
        @(negedge clk); sclk = 1'b0;
        repeat (3) @(negedge clk);
        csb = 1'b1;
        repeat (3) @(negedge clk);
        check("R2 idle enables", {sdo_oe, sdio_oe}, 2'b00);
    endtask

    task automatic do_cycle(input logic rw, input logic [1:0] n, input logic [4:0] a0,
                            input logic [31:0] d, input string tag);
        logic [4:0] a = a0;
        logic [7:0] got;
        logic ok;
        start_cycle();
        send_byte({rw, n, a0});
        for (int i = 0; i <= int'(n); i++) begin
            if (!rw) begin
                send_byte(d[i*8 +: 8]);
                model_write(a, d[i*8 +: 8]);
            end else begin
                recv_byte(got, ok);
                check({tag, " read data"}, got, m[a]);
                check({tag, " R7 enables"}, ok, 1'b1);
            end
            a = step(a, m[0][6]);
        end
        end_cycle();
        check_regs(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic d, s1, s2;
        int unsigned seed0 = $urandom(32'd20240611);
        for (int i = 0; i < 32; i++) m[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_regs("R1 reset");
        check("R2 reset enables", {sdo_oe, sdio_oe}, 2'b00);

        // R3 directed MSB-first write then read
        do_cycle(1'b0, 2'd1, 5'd12, 32'h0000_A55A, "R3 write");
        do_cycle(1'b1, 2'd1, 5'd12, 32'h0, "R3 read");

        // R3 random transactions, MSB-first
        for (int t = 0; t < 25; t++)
            do_cycle(1'($urandom % 2), 2'($urandom % 4), 5'(1 + $urandom % 31), $urandom, "R3 random");

        // R6 floor: read 1,0,0,0
        do_cycle(1'b1, 2'd3, 5'd1, 32'h0, "R6 floor");

        // R5 extra byte ignored
        start_cycle();
        send_byte({1'b0, 2'b00, 5'd9});
        send_byte(8'h77); model_write(5'd9, 8'h77);
        send_byte(8'hEE);
        end_cycle();
        check_regs("R5 extra byte");

        // R10 partial byte discarded
        start_cycle();
        for (int k = 0; k < 5; k++) clk_bit(1'b1, d, s1, s2);
        end_cycle();
        do_cycle(1'b0, 2'd0, 5'd3, 32'h5A, "R10 after partial");

        // R8 mid-cycle switch to LSB-first, second byte at address 1
        do_cycle(1'b0, 2'd1, 5'd0, 32'h0000_C340, "R8 switch");
        do_cycle(1'b1, 2'd0, 5'd1, 32'h0, "R8 readback");

        // R4 random transactions, LSB-first
        for (int t = 0; t < 15; t++)
            do_cycle(1'($urandom % 2), 2'($urandom % 4), 5'(1 + $urandom % 31), $urandom, "R4 random");
        // R6 ceiling: write 30,31,31,31
        do_cycle(1'b0, 2'd3, 5'd30, 32'h1122_3344, "R6 ceiling");
        do_cycle(1'b1, 2'd1, 5'd30, 32'h0, "R6 ceiling read");

        // R7 3-wire read, then back to 4-wire MSB-first
        do_cycle(1'b0, 2'd0, 5'd0, 32'h80, "R7 set 3-wire");
        do_cycle(1'b1, 2'd2, 5'd12, 32'h0, "R7 3-wire read");
        do_cycle(1'b0, 2'd0, 5'd0, 32'h00, "R7 restore");
        do_cycle(1'b1, 2'd1, 5'd13, 32'h0, "R7 4-wire read");

        // R9 soft reset keeps registers 0 and 4
        do_cycle(1'b0, 2'd3, 5'd5, 32'hDEAD_BEEF, "R9 fill");
        do_cycle(1'b0, 2'd0, 5'd0, 32'h20, "R9 soft reset");
        do_cycle(1'b1, 2'd1, 5'd5, 32'h0, "R9 readback");

        // R11 recovery from 3-wire LSB-first
        do_cycle(1'b0, 2'd0, 5'd0, 32'hC0, "R11 scramble");
        start_cycle();
        for (int k = 0; k < 27; k++) clk_bit(1'b0, d, s1, s2);
        end_cycle();
        m[0] = 8'h00;
        check_regs("R11 recovery");
        do_cycle(1'b1, 2'd0, 5'd4, 32'h0, "R11 read after");

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        if (seed0 == 0) $display("seed zero");
        $finish;
    end
endmodule